// File: doc/BRIEF.md
# Shift-Clock-Driven Grayscale PWM Engine

This block produces twelve pulse-width-modulated outputs, arranged as four groups of red, green and blue, from twelve 16-bit grayscale words. It has no oscillator of its own. The clock that shifts serial data into the device is also its grayscale reference, so every rising edge of that clock is one step of the display period. A full period is 65536 steps.

The words and three control flags (blank, repeat, timing reset) reach the block in parallel from the shift register logic next to it. They are taken in only on a latch strobe, so the words on the input can change freely between strobes. A strobe with the timing-reset flag set starts a new period. The next clock edge is then step 0, and every channel with a nonzero word turns on at that edge. Channel n stays on while the step count is below its word and goes off when the count reaches it. With repeat clear the engine runs one period and then stops. With repeat set it wraps and runs again. The blank flag forces every output low; it is set at reset.

The block has no streaming data path. The latch strobe and the flags are plain level controls sampled on the clock, and the block never pushes back on its source.

Top module: `gs_pwm_engine`

## Requirements
- R1: After reset the held blank flag is 1, the engine is stopped, all held words are 0 and `pwm_out` is all zeros.
- R2: While running, each rising clock edge without a latch strobe advances the step count by one, so a period is 65536 counted edges (steps 0 to 65535).
- R3: At the edge for step k, output n is set on when k is less than the held word n and set off otherwise. Nonzero channels therefore turn on at step 0, and a word of FFFFh stays on for 65535 of the 65536 steps.
- R4: A channel whose held word is 0000h is off after every counted edge.
- R5: While the held blank flag is 1, `pwm_out` is all zeros whatever the step count and words are.
- R6: Words and flags are captured only on an edge where `latch_strobe` is 1. Changes on `gs_words` and on the flag inputs have no effect at any other edge.
- R7: A latch edge with `ctl_tmrst` = 1 sets the step count to 0, starts the engine and turns all outputs off. The following edge is step 0 of the new period.
- R8: A latch edge with `ctl_tmrst` = 0 is not counted. The step count, the running state and the output states all hold, and the new words apply from the next counted edge.
- R9: With the held repeat flag at 0, the engine stops after the step-65535 edge. Outputs stay off until a latch with timing reset.
- R10: With the held repeat flag at 1, the step after 65535 is 0 of a new period and the engine keeps running.
- R11: Word n is `gs_words[16n+15:16n]` and drives `pwm_out[n]`. Channel n belongs to group n/3, and n mod 3 selects the color: 0 red, 1 green, 2 blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock, also the grayscale step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_strobe | input | 1 | Captures words and flags at this edge |
| gs_words | input | 192 | Twelve packed 16-bit grayscale words |
| ctl_blank | input | 1 | Blank flag to capture (1 = outputs forced off) |
| ctl_repeat | input | 1 | Repeat flag to capture (1 = periods repeat) |
| ctl_tmrst | input | 1 | Timing-reset flag, acts at the latch edge |
| pwm_out | output | 12 | Channel outputs, bit n for channel n |

## Verification
On every cycle the assertions check how the counter moves: a single step per counted edge, restart to zero at a timing-reset latch, holding at a plain latch, and stopping or wrapping at the period end. They also check that the held words never change outside a latch, that blank and a stopped engine leave every output dark, and how zero and nonzero words behave at the first step. Only the bench scenarios can show the full on-time of each word value across a whole 65536-step period, that word changes between strobes leave the waveform as it was, and that the new words take effect at the right step after a latch without timing reset.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

  localparam int COLORS_PER_GROUP = 3;

  typedef enum logic [1:0] {
    COLOR_RED   = 2'd0,
    COLOR_GREEN = 2'd1,
    COLOR_BLUE  = 2'd2
  } color_e;

  typedef struct packed {
    logic blank;
    logic repeat_en;
    logic tmrst;
  } ctl_flags_t;

  localparam ctl_flags_t FLAGS_RESET = '{blank: 1'b1, repeat_en: 1'b0, tmrst: 1'b0};

  function automatic color_e color_of(input int unsigned chan);
    return color_e'(chan % COLORS_PER_GROUP);
  endfunction

endpackage

// File: rtl/gs_latch_bank.sv
module gs_latch_bank
  import gs_pwm_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NCH*CNT_W-1:0]   words_in,
  input  ctl_flags_t             flags_in,
  output logic [NCH*CNT_W-1:0]   words_q,
  output ctl_flags_t             flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RESET;
    end else if (load) begin
      flags_q <= flags_in;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[n*CNT_W +: CNT_W] <= '0;
      end else if (load) begin
        words_q[n*CNT_W +: CNT_W] <= words_in[n*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/gs_period_ctr.sv
module gs_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tmrst_in,
  input  logic             repeat_en,
  output logic [CNT_W-1:0] pos_q,
  output logic             run_q,
  output logic             step,
  output logic             hold
);

  localparam logic [CNT_W-1:0] LAST_STEP = '1;

  logic restart;

  assign restart = load & tmrst_in;
  assign hold    = load & ~tmrst_in;
  assign step    = run_q & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= 1'b0;
    end else if (restart) begin
      pos_q <= '0;
      run_q <= 1'b1;
    end else if (step) begin
      if (pos_q == LAST_STEP) begin
        pos_q <= '0;
        run_q <= repeat_en;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gs_chan_cmp.sv
module gs_chan_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             hold,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] level,
  output logic             on_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
    end else if (step) begin
      on_q <= (pos < level);
    end else if (!hold) begin
      on_q <= 1'b0;
    end
  end

endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine
  import gs_pwm_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int CNT_W  = 16,
  localparam int NCH   = GROUPS * COLORS_PER_GROUP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 latch_strobe,
  input  logic [NCH*CNT_W-1:0] gs_words,
  input  logic                 ctl_blank,
  input  logic                 ctl_repeat,
  input  logic                 ctl_tmrst,
  output logic [NCH-1:0]       pwm_out
);

  ctl_flags_t           flags_in;
  ctl_flags_t           flags_w;
  logic [NCH*CNT_W-1:0] words_w;
  logic [CNT_W-1:0]     pos_w;
  logic                 run_w;
  logic                 step_w;
  logic                 hold_w;
  logic [NCH-1:0]       on_w;

  assign flags_in = '{blank: ctl_blank, repeat_en: ctl_repeat, tmrst: ctl_tmrst};

  gs_latch_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (latch_strobe),
    .words_in (gs_words),
    .flags_in (flags_in),
    .words_q  (words_w),
    .flags_q  (flags_w)
  );

  gs_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (latch_strobe),
    .tmrst_in  (ctl_tmrst),
    .repeat_en (flags_w.repeat_en),
    .pos_q     (pos_w),
    .run_q     (run_w),
    .step      (step_w),
    .hold      (hold_w)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    gs_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step_w),
      .hold  (hold_w),
      .pos   (pos_w),
      .level (words_w[n*CNT_W +: CNT_W]),
      .on_q  (on_w[n])
    );
  end

  assign pwm_out = flags_w.blank ? '0 : on_w;

endmodule

// File: rtl/gs_pwm_engine_chk.sv
module gs_pwm_engine_chk #(
  parameter int NCH   = 12,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 latch_strobe,
  input logic                 ctl_tmrst,
  input logic [NCH-1:0]       pwm_out,
  input logic [CNT_W-1:0]     pos,
  input logic                 run,
  input logic                 blank,
  input logic                 repeat_en,
  input logic [NCH*CNT_W-1:0] shadow
);

  localparam logic [CNT_W-1:0] LAST_STEP = '1;

  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !latch_strobe && pos != LAST_STEP) |=> (pos == $past(pos) + 1'b1)); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_strobe && ctl_tmrst) |=> (pos == '0 && run && pwm_out == '0)); // R7

  AST_PLAIN_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_strobe && !ctl_tmrst) |=> ($stable(pos) && $stable(run))); // R8

  AST_SINGLE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !latch_strobe && pos == LAST_STEP && !repeat_en) |=> !run); // R9

  AST_WRAP_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !latch_strobe && pos == LAST_STEP && repeat_en) |=> (run && pos == '0)); // R10

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (pwm_out == '0)); // R5

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == '0)); // R9

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_strobe |=> $stable(shadow)); // R6

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    AST_ZERO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !latch_strobe && shadow[n*CNT_W +: CNT_W] == '0) |=> !pwm_out[n]); // R4

    AST_FIRST_STEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !latch_strobe && pos == '0 && !blank && shadow[n*CNT_W +: CNT_W] != '0)
        |=> pwm_out[n]); // R3
  end

endmodule

bind gs_pwm_engine gs_pwm_engine_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .latch_strobe (latch_strobe),
  .ctl_tmrst    (ctl_tmrst),
  .pwm_out      (pwm_out),
  .pos          (pos_w),
  .run          (run_w),
  .blank        (flags_w.blank),
  .repeat_en    (flags_w.repeat_en),
  .shadow       (words_w)
);

// File: tb/gs_pwm_engine_tb.sv
module gs_pwm_engine_tb;

  localparam int NCH   = 12;
  localparam int CNT_W = 16;
  localparam int LAST  = 65535;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 latch_strobe = 1'b0;
  logic [NCH*CNT_W-1:0] gs_words = '0;
  logic                 ctl_blank = 1'b0;
  logic                 ctl_repeat = 1'b0;
  logic                 ctl_tmrst = 1'b0;
  logic [NCH-1:0]       pwm_out;

  int    n_checks = 0;
  int    n_fail = 0;
  string phase = "R1";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;

  // behavioural reference state
  int       m_pos = 0;
  bit       m_run = 0;
  bit       m_blank = 1;
  bit       m_rep = 0;
  int       m_gs[NCH];
  bit [NCH-1:0] m_on = '0;

  always #2 clk = ~clk;

  gs_pwm_engine u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_strobe (latch_strobe),
    .gs_words     (gs_words),
    .ctl_blank    (ctl_blank),
    .ctl_repeat   (ctl_repeat),
    .ctl_tmrst    (ctl_tmrst),
    .pwm_out      (pwm_out)
  );

  task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out actual %03h expected %03h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_run = 0; m_blank = 1; m_rep = 0; m_on = '0;
      for (int n = 0; n < NCH; n++) m_gs[n] = 0;
    end else if (latch_strobe) begin
      for (int n = 0; n < NCH; n++) m_gs[n] = int'(gs_words[n*CNT_W +: CNT_W]);
      m_blank = ctl_blank;
      m_rep   = ctl_repeat;
      if (ctl_tmrst) begin
        m_pos = 0; m_run = 1; m_on = '0;
      end
    end else if (m_run) begin
      for (int n = 0; n < NCH; n++) m_on[n] = (m_pos < m_gs[n]);
      if (m_pos == LAST) begin
        m_pos = 0; m_run = m_rep;
      end else begin
        m_pos++;
      end
    end else begin
      m_on = '0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) check({phase, " per-cycle"}, pwm_out, m_blank ? '0 : m_on);
  end

  task automatic steps(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_latch(input logic [NCH*CNT_W-1:0] w, input bit b, input bit r, input bit t);
    gs_words = w; ctl_blank = b; ctl_repeat = r; ctl_tmrst = t; latch_strobe = 1'b1;
    @(negedge clk);
    latch_strobe = 1'b0;
  endtask

  function automatic logic [NCH*CNT_W-1:0] pack_words(input int sel);
    logic [NCH*CNT_W-1:0] v;
    for (int n = 0; n < NCH; n++) begin
      logic [CNT_W-1:0] x;
      case (sel)
        0: case (n)
             0: x = 16'h0000; 1: x = 16'h0001; 2: x = 16'h0002;
             3: x = 16'hFFFF; 4: x = 16'h0003; 5: x = 16'h8000;
             default: x = 16'h0100;
           endcase
        1: x = 16'(10 * (n + 1));
        2: x = 16'd200;
        default: x = 16'hFFFF;
      endcase
      v[n*CNT_W +: CNT_W] = x;
    end
    return v;
  endfunction

  initial begin
    steps(3);
    check("R1 reset outputs", pwm_out, '0);
    rst_n = 1'b1;
    steps(2);
    check("R1 idle after reset", pwm_out, '0);
    cmp_en = 1'b1;

    // Single period, no repeat
    phase = "R3";
    do_latch(pack_words(0), 1'b0, 1'b0, 1'b1);
    check("R7 latch edge dark", pwm_out, '0);
    steps(1);
    check("R3 R4 R11 step0 nonzero on", pwm_out, 12'hFFE);
    steps(1);
    check("R3 step1 word1 off", pwm_out, 12'hFFC);
    phase = "R6";
    gs_words = pack_words(3);
    ctl_blank = 1'b1;
    steps(1);
    check("R6 unlatched words ignored step2", pwm_out, 12'hFF8);
    steps(1);
    check("R6 R3 step3", pwm_out, 12'hFE8);
    phase = "R3";
    steps(LAST - 1 - 3);
    check("R3 FFFF on at step 65534", pwm_out, 12'h008);
    phase = "R9";
    steps(1);
    check("R3 R9 FFFF off at last step", pwm_out, '0);
    steps(5);
    check("R9 stopped after one period", pwm_out, '0);

    // Blank
    phase = "R5";
    do_latch(pack_words(3), 1'b1, 1'b0, 1'b1);
    steps(50);
    check("R5 blank forces dark", pwm_out, '0);

    // Repeat plus plain latch
    phase = "R2";
    do_latch(pack_words(1), 1'b0, 1'b1, 1'b1);
    steps(100);
    check("R2 R3 after step 99", pwm_out, 12'hE00);
    phase = "R8";
    do_latch(pack_words(2), 1'b0, 1'b1, 1'b0);
    check("R8 plain latch holds outputs", pwm_out, 12'hE00);
    steps(1);
    check("R8 new words from next step", pwm_out, 12'hFFF);
    phase = "R10";
    steps(LAST - 100);
    check("R10 last step dark", pwm_out, '0);
    steps(1);
    check("R10 wrapped to step 0", pwm_out, 12'hFFF);
    steps(250);
    check("R10 still running after wrap", pwm_out, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule